// File: doc/BRIEF.md
# Interleaved Dual-Channel PWM Gate Generator

This block produces two fixed-frequency pulse-width-modulated outputs for synchronous buck stages. Each output is a complementary pair made of a high-side gate and a low-side gate. Both channels run from one free-running counter of `2^CNT_W` clocks. The second channel's period starts half a period after the first channel's period, so the input current peaks of the two stages do not line up. Each channel has a duty word and an enable.

Channel 1 has two extra inputs. A standby request halves its period. While standby is active, its duty word is scaled to the shorter period. Channel 1 also has a current-limit comparator input. This input is examined only while the channel's high-side gate is on, and only after a blanking window that follows each turn-on. A hit sets a sticky fault, and the fault shuts down all four gates until reset.

Top module: `interleaved_pwm`

## Requirements
- R1: With standby inactive, each channel repeats with a period of N = 2^CNT_W clocks. The rising edges of a high-side gate are N clocks apart.
- R2: Channel 2's high-side rising edge follows channel 1's by N/2 clocks when both channels have the same duty word.
- R3: With standby active, channel 1 repeats every N/2 clocks and uses duty word D shifted right by one. Channel 2 is unaffected. A standby change takes effect only at a boundary of the full N-clock period.
- R4: Duty word 0 keeps the high-side gate off and the low-side gate on continuously. A duty word of N or more (the word has CNT_W+1 bits) keeps the high-side gate on continuously and the low-side gate off.
- R5: Let Neff be the channel's period and De its effective duty. When DEAD_CYC+2 <= De <= Neff-DEAD_CYC-2, each period has the high-side gate high for De-DEAD_CYC-1 clocks and the low-side gate high for Neff-De-DEAD_CYC-1 clocks.
- R6: The two gates of a channel are never high together. Before either gate rises, both gates have been low for at least DEAD_CYC clocks.
- R7: A duty word is captured only at the start of that channel's period. Every high-side pulse therefore has the width set by either the old word or the new word.
- R8: While a channel's enable is low, both of its gates are low from the next clock onward.
- R9: The current-limit input is ignored while channel 1's high-side gate is low. It is also ignored during the first BLANK_CYC clocks of each high-side on-time.
- R10: The current-limit input high while the high-side gate has been on for BLANK_CYC or more clocks sets the fault output on the next clock. The fault stays set until reset.
- R11: While the fault is set, all four gates are low.
- R12: During and right after reset, all gates and the fault output are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ch1Duty | input | CNT_W+1 | Channel 1 duty word (0 to N, values above N act as N) |
| ch2Duty | input | CNT_W+1 | Channel 2 duty word |
| ch1En | input | 1 | Channel 1 enable |
| ch2En | input | 1 | Channel 2 enable |
| ch1Standby | input | 1 | Channel 1 double-frequency request |
| ch1Ilim | input | 1 | Channel 1 current-limit comparator result |
| ch1HighGate | output | 1 | Channel 1 high-side gate |
| ch1LowGate | output | 1 | Channel 1 low-side gate |
| ch2HighGate | output | 1 | Channel 2 high-side gate |
| ch2LowGate | output | 1 | Channel 2 low-side gate |
| ocFault | output | 1 | Sticky overcurrent fault |

## Verification
The bench checks the blanking edge from both sides. A current-limit pulse covering exactly the first BLANK_CYC clocks of an on-time must not trip the fault. A pulse one clock longer must trip it. A window that is off by one would fail one of those two cases. The bench also changes a duty word in the middle of a high-side pulse and measures that pulse. A design that loads duty immediately would stretch or cut the pulse to a width that is neither the old nor the new one. The duty extremes 0 and N, and words above N, are driven to catch wrong comparison sizing, which shows up as a stray one-clock pulse or a gap. Random duties in both modes are checked against the dead-time-reduced widths and against zero overlap of the gates.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Strobes from the timebase control to the gate datapath
  typedef struct packed {
    logic load1;   // channel 1 period starts on the next clock
    logic load2;   // channel 2 period starts on the next clock
    logic stby;    // channel 1 runs the half-length period
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stbyReq,
  output pwm_strobe_t      strb,
  output logic [CNT_W-1:0] phase1,
  output logic [CNT_W-1:0] phase2
);
  localparam logic [CNT_W-1:0] LAST_CNT  = '1;
  localparam logic [CNT_W-1:0] HALF_LAST = LAST_CNT >> 1;

  logic [CNT_W-1:0] cnt;
  logic             stbyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      stbyQ <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_CNT) stbyQ <= stbyReq;  // mode changes only at a full-period boundary
    end
  end

  always_comb begin
    phase1     = stbyQ ? (cnt & HALF_LAST) : cnt;
    phase2     = {~cnt[CNT_W-1], cnt[CNT_W-2:0]};  // half-period offset
    strb.load1 = stbyQ ? ((cnt & HALF_LAST) == HALF_LAST) : (cnt == LAST_CNT);
    strb.load2 = (cnt == HALF_LAST);
    strb.stby  = stbyQ;
  end
endmodule

// File: rtl/pwm_gate_channel.sv
module pwm_gate_channel #(
  parameter int CNT_W    = 8,
  parameter int DEAD_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             kill,
  input  logic             load,
  input  logic             stby,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W:0]   duty,
  output logic             hsGate,
  output logic             lsGate
);
  localparam int OFF_W = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [OFF_W-1:0] OFF_DONE = OFF_W'(DEAD_CYC);

  logic [CNT_W:0]   dutyQ;
  logic [CNT_W:0]   dutyEff;
  logic             req;
  logic             run;
  logic [OFF_W-1:0] offCnt;

  assign dutyEff = stby ? (dutyQ >> 1) : dutyQ;
  assign req     = ({1'b0, phase} < dutyEff);
  assign run     = en && !kill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ  <= '0;
      offCnt <= '0;
      hsGate <= 1'b0;
      lsGate <= 1'b0;
    end else begin
      if (load) dutyQ <= duty;
      if (hsGate || lsGate)      offCnt <= '0;
      else if (offCnt != OFF_DONE) offCnt <= offCnt + 1'b1;
      hsGate <= run &&  req && (hsGate || (!lsGate && offCnt == OFF_DONE));
      lsGate <= run && !req && (lsGate || (!hsGate && offCnt == OFF_DONE));
    end
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEAD_CYC  = 4,
  parameter int BLANK_CYC = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwm_strobe_t      strb,
  input  logic [CNT_W-1:0] phase1,
  input  logic [CNT_W-1:0] phase2,
  input  logic [CNT_W:0]   duty1,
  input  logic [CNT_W:0]   duty2,
  input  logic             en1,
  input  logic             en2,
  input  logic             ilim,
  output logic [1:0]       hsGate,
  output logic [1:0]       lsGate,
  output logic             fault
);
  localparam int NUM_CH  = 2;
  localparam int BLANK_W = $clog2(BLANK_CYC + 1) + 1;
  localparam logic [BLANK_W-1:0] BLANK_DONE = BLANK_W'(BLANK_CYC);

  logic [CNT_W-1:0] phaseArr [NUM_CH];
  logic [CNT_W:0]   dutyArr  [NUM_CH];
  logic [NUM_CH-1:0] enArr, loadArr, stbyArr;
  logic [BLANK_W-1:0] blankCnt;

  assign phaseArr[0] = phase1;
  assign phaseArr[1] = phase2;
  assign dutyArr[0]  = duty1;
  assign dutyArr[1]  = duty2;
  assign enArr       = {en2, en1};
  assign loadArr     = {strb.load2, strb.load1};
  assign stbyArr     = {1'b0, strb.stby};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_gate_channel #(.CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .en     (enArr[ch]),
      .kill   (fault),
      .load   (loadArr[ch]),
      .stby   (stbyArr[ch]),
      .phase  (phaseArr[ch]),
      .duty   (dutyArr[ch]),
      .hsGate (hsGate[ch]),
      .lsGate (lsGate[ch])
    );
  end

  // Blanking window after each channel-1 high-side turn-on, then sticky trip
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
      fault    <= 1'b0;
    end else begin
      if (!hsGate[0])                blankCnt <= '0;
      else if (blankCnt != BLANK_DONE) blankCnt <= blankCnt + 1'b1;
      if (hsGate[0] && blankCnt == BLANK_DONE && ilim) fault <= 1'b1;
    end
  end
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEAD_CYC  = 4,
  parameter int BLANK_CYC = 26
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CNT_W:0] ch1Duty,
  input  logic [CNT_W:0] ch2Duty,
  input  logic           ch1En,
  input  logic           ch2En,
  input  logic           ch1Standby,
  input  logic           ch1Ilim,
  output logic           ch1HighGate,
  output logic           ch1LowGate,
  output logic           ch2HighGate,
  output logic           ch2LowGate,
  output logic           ocFault
);
  pwm_strobe_t      strb;
  logic [CNT_W-1:0] phase1, phase2;
  logic [1:0]       hsGate, lsGate;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rstN    (rstN),
    .stbyReq (ch1Standby),
    .strb    (strb),
    .phase1  (phase1),
    .phase2  (phase2)
  );

  pwm_datapath #(.CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .phase1 (phase1),
    .phase2 (phase2),
    .duty1  (ch1Duty),
    .duty2  (ch2Duty),
    .en1    (ch1En),
    .en2    (ch2En),
    .ilim   (ch1Ilim),
    .hsGate (hsGate),
    .lsGate (lsGate),
    .fault  (ocFault)
  );

  assign ch1HighGate = hsGate[0];
  assign ch1LowGate  = lsGate[0];
  assign ch2HighGate = hsGate[1];
  assign ch2LowGate  = lsGate[1];
endmodule

// File: rtl/interleaved_pwm_chk.sv
module interleaved_pwm_chk #(
  parameter int CNT_W     = 8,
  parameter int DEAD_CYC  = 4,
  parameter int BLANK_CYC = 26
) (
  input logic           clk,
  input logic           rstN,
  input logic [CNT_W:0] ch1Duty,
  input logic [CNT_W:0] ch2Duty,
  input logic           ch1En,
  input logic           ch2En,
  input logic           ch1Standby,
  input logic           ch1Ilim,
  input logic           ch1HighGate,
  input logic           ch1LowGate,
  input logic           ch2HighGate,
  input logic           ch2LowGate,
  input logic           ocFault
);
  logic [15:0] gap1, gap2, onCnt1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap1   <= '0;
      gap2   <= '0;
      onCnt1 <= '0;
    end else begin
      if (ch1HighGate || ch1LowGate) gap1 <= '0;
      else if (gap1 != 16'hFFFF)     gap1 <= gap1 + 1'b1;
      if (ch2HighGate || ch2LowGate) gap2 <= '0;
      else if (gap2 != 16'hFFFF)     gap2 <= gap2 + 1'b1;
      if (!ch1HighGate)              onCnt1 <= '0;
      else if (onCnt1 != 16'hFFFF)   onCnt1 <= onCnt1 + 1'b1;
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ch1HighGate && ch1LowGate) && !(ch2HighGate && ch2LowGate));

  p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ch1HighGate) || $rose(ch1LowGate)) |-> (gap1 >= 16'(DEAD_CYC)));

  p_dead_gap2_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ch2HighGate) || $rose(ch2LowGate)) |-> (gap2 >= 16'(DEAD_CYC)));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ch1En |=> (!ch1HighGate && !ch1LowGate));

  p_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocFault) |-> $past(ch1HighGate && ch1Ilim && (onCnt1 >= 16'(BLANK_CYC))));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ocFault |=> ocFault);

  p_fault_gates_r11: assert property (@(posedge clk) disable iff (!rstN)
    ocFault |=> (!ch1HighGate && !ch1LowGate && !ch2HighGate && !ch2LowGate));
endmodule

bind interleaved_pwm interleaved_pwm_chk #(
  .CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)
) u_chk (.*);

// File: tb/interleaved_pwm_tb.sv
module interleaved_pwm_tb;
  localparam int CNT_W = 8;
  localparam int DEAD  = 4;
  localparam int BLANK = 26;
  localparam int N     = 1 << CNT_W;

  logic clk = 1'b0;
  logic rstN;
  logic [CNT_W:0] ch1Duty, ch2Duty;
  logic ch1En, ch2En, ch1Standby, ch1Ilim;
  logic ch1HighGate, ch1LowGate, ch2HighGate, ch2LowGate, ocFault;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interleaved_pwm #(.CNT_W(CNT_W), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expHs(input int d, input bit sb);
    int ne = sb ? N / 2 : N;
    int de = sb ? d / 2 : d;
    int per;
    if (de >= ne)            per = ne;
    else if (de <= DEAD + 1) per = 0;
    else                     per = de - DEAD - 1;
    return per * (N / ne);
  endfunction

  function automatic int expLs(input int d, input bit sb);
    int ne = sb ? N / 2 : N;
    int de = sb ? d / 2 : d;
    int per;
    if (de == 0)       per = ne;
    else if (de >= ne) per = 0;
    else               per = ne - de - DEAD - 1;
    return per * (N / ne);
  endfunction

  task automatic window(output int h1, output int l1, output int h2,
                        output int l2, output int ov);
    h1 = 0; l1 = 0; h2 = 0; l2 = 0; ov = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      h1 += int'(ch1HighGate); l1 += int'(ch1LowGate);
      h2 += int'(ch2HighGate); l2 += int'(ch2LowGate);
      if ((ch1HighGate && ch1LowGate) || (ch2HighGate && ch2LowGate)) ov++;
    end
  endtask

  task automatic waitRise1(output longint t);
    logic prev;
    prev = ch1HighGate;
    forever begin
      @(negedge clk);
      if (ch1HighGate && !prev) break;
      prev = ch1HighGate;
    end
    t = cyc;
  endtask

  task automatic waitRise2(output longint t);
    logic prev;
    prev = ch2HighGate;
    forever begin
      @(negedge clk);
      if (ch2HighGate && !prev) break;
      prev = ch2HighGate;
    end
    t = cyc;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h1, l1, h2, l2, ov, w, k, dA, dB;
    bit sb;
    longint ta, tb, tc;
    void'($urandom(32'd20240607));
    rstN = 1'b0; ch1Duty = '0; ch2Duty = '0; ch1En = 1'b0; ch2En = 1'b0;
    ch1Standby = 1'b0; ch1Ilim = 1'b0;
    settle(5);
    // R12: reset state
    chk(!ch1HighGate && !ch1LowGate && !ch2HighGate && !ch2LowGate, "R12", "gates in reset",
        {ch1HighGate, ch1LowGate, ch2HighGate, ch2LowGate}, 0);
    chk(!ocFault, "R12", "fault in reset", ocFault, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ch1HighGate && !ch1LowGate && !ocFault, "R12", "gates after reset",
        {ch1HighGate, ch1LowGate, ocFault}, 0);

    // R4: duty extremes
    ch1En = 1'b1; ch2En = 1'b1; ch1Duty = 0; ch2Duty = 9'(N);
    settle(3 * N);
    window(h1, l1, h2, l2, ov);
    chk(h1 == 0 && l1 == N, "R4", "duty 0 high/low count", h1 * 1000 + l1, N);
    chk(h2 == N && l2 == 0, "R4", "duty N high/low count", h2 * 1000 + l2, N * 1000);
    ch1Duty = 9'd400;
    settle(3 * N);
    window(h1, l1, h2, l2, ov);
    chk(h1 == N && l1 == 0, "R4", "duty above N high count", h1 * 1000 + l1, N * 1000);

    // R1 / R2: period and interleave
    ch1Duty = 100; ch2Duty = 100;
    settle(3 * N);
    waitRise1(ta); waitRise1(tb);
    chk(tb - ta == N, "R1", "ch1 rise-to-rise", tb - ta, N);
    waitRise2(tc);
    chk(tc - tb == N / 2, "R2", "ch2 lag after ch1", tc - tb, N / 2);
    waitRise2(ta);
    chk(ta - tc == N, "R1", "ch2 rise-to-rise", ta - tc, N);

    // R3: standby doubles channel 1 rate only
    ch1Standby = 1'b1;
    settle(3 * N);
    waitRise1(ta); waitRise1(tb);
    chk(tb - ta == N / 2, "R3", "ch1 standby period", tb - ta, N / 2);
    waitRise2(ta); waitRise2(tb);
    chk(tb - ta == N, "R3", "ch2 period in standby", tb - ta, N);

    // R5 / R6 / R3: random duties in both modes
    for (int it = 0; it < 12; it++) begin
      dA = $urandom_range(16, 230);
      dB = $urandom_range(16, 230);
      sb = 1'($urandom_range(0, 1));
      ch1Duty = 9'(dA); ch2Duty = 9'(dB); ch1Standby = sb;
      settle(3 * N);
      window(h1, l1, h2, l2, ov);
      chk(h1 == expHs(dA, sb), sb ? "R3" : "R5", "ch1 high count", h1, expHs(dA, sb));
      chk(l1 == expLs(dA, sb), sb ? "R3" : "R5", "ch1 low count", l1, expLs(dA, sb));
      chk(h2 == expHs(dB, 0) && l2 == expLs(dB, 0), "R5", "ch2 high/low count",
          h2 * 1000 + l2, expHs(dB, 0) * 1000 + expLs(dB, 0));
      chk(ov == 0, "R6", "gate overlap cycles", ov, 0);
    end

    // R7: duty change in mid-pulse does not alter the running pulse
    ch1Standby = 1'b0; ch1Duty = 60;
    settle(3 * N);
    for (int it = 0; it < 4; it++) begin
      dA = (it % 2 == 0) ? 60 : 150;
      dB = (it % 2 == 0) ? 150 : 60;
      waitRise1(ta);
      w = 1;
      k = $urandom_range(1, 40);
      while (ch1HighGate) begin
        if (w == k) ch1Duty = 9'(dB);
        @(negedge clk);
        if (ch1HighGate) w++;
      end
      chk(w == dA - DEAD - 1, "R7", "pulse width during change", w, dA - DEAD - 1);
      waitRise1(ta);
      w = 1;
      while (ch1HighGate) begin
        @(negedge clk);
        if (ch1HighGate) w++;
      end
      chk(w == dB - DEAD - 1, "R7", "pulse width after change", w, dB - DEAD - 1);
    end

    // R8: disable drives both gates low, other channel keeps running
    ch1Duty = 100; ch2Duty = 100; ch1En = 1'b0;
    settle(3 * N);
    window(h1, l1, h2, l2, ov);
    chk(h1 == 0 && l1 == 0, "R8", "disabled ch1 gate count", h1 + l1, 0);
    chk(h2 == expHs(100, 0), "R8", "ch2 high count with ch1 off", h2, expHs(100, 0));

    // R9: blanking boundary and ignore while high side off
    ch1En = 1'b1; ch1Duty = 128;
    settle(3 * N);
    waitRise1(ta);
    ch1Ilim = 1'b1;
    repeat (BLANK - 1) @(negedge clk);
    @(negedge clk);
    ch1Ilim = 1'b0;
    settle(10);
    chk(!ocFault, "R9", "fault after ilim inside blanking", ocFault, 0);
    while (!ch1LowGate) @(negedge clk);
    ch1Ilim = 1'b1;
    settle(20);
    ch1Ilim = 1'b0;
    settle(N);
    chk(!ocFault, "R9", "fault after ilim with high side off", ocFault, 0);

    // R10 / R11: one clock past blanking trips and latches
    waitRise1(ta);
    ch1Ilim = 1'b1;
    repeat (BLANK) @(negedge clk);
    @(negedge clk);
    ch1Ilim = 1'b0;
    settle(3);
    chk(ocFault, "R10", "fault after ilim past blanking", ocFault, 1);
    settle(2 * N);
    chk(ocFault, "R10", "fault sticky", ocFault, 1);
    window(h1, l1, h2, l2, ov);
    chk(h1 + l1 + h2 + l2 == 0, "R11", "gate count under fault", h1 + l1 + h2 + l2, 0);

    // R12: reset clears the fault
    rstN = 1'b0;
    settle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ocFault, "R12", "fault after reset", ocFault, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule